// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt lines from the rest of the chip and turns them into one interrupt request for a processor. The number of lines and the trigger type of each line are fixed when the block is built. Each line is either edge-triggered, which latches on a rising transition, or level-sensitive, which latches while the line is high. A latched line stays latched until software acknowledges it. The request to the processor is raised when a latched line is also enabled and both master enable bits are set.

Software reaches the controller through a single-cycle 32-bit register port. The port has a byte address, a write strobe, a read strobe and write and read data. Through it, software reads the latched, pending and enable state. It acknowledges lines by writing ones. It can replace the enable bits in one write, or set and clear individual enable bits without a read-modify-write sequence. It reads a vector register that gives the lowest-numbered pending line, or all ones when no line is pending. The interrupt lines are assumed to be synchronous to `clk`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register words sit at these byte addresses: 0x00 latched status, 0x04 pending (status AND enable), 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master. A read of 0x0C, 0x10 or 0x14 returns zero. An access whose two low address bits are not zero is ignored, and a read of such an address returns zero.
- R2: The master word keeps bits 1:0 of the last write, and its other bits read as zero. `irq_req` can be high only when both bit 0 and bit 1 are set.
- R3: Writing a one to bit i of the acknowledge word clears status bit i. Zero bits leave their status bits unchanged.
- R4: A write to 0x08 replaces every enable bit. Writing ones to 0x10 sets the selected enable bits, and writing ones to 0x14 clears them. Enable bits that are not selected keep their value.
- R5: A line whose bit in `EDGE_MASK` is 1 sets its status bit on a rising transition only. While the line stays high it does not latch again after an acknowledge. A rising transition in the same cycle as its acknowledge still latches.
- R6: A line whose bit in `EDGE_MASK` is 0 sets its status bit in every cycle it is high. In the cycle of its acknowledge it reads cleared, and it latches again on the next cycle if it is still high.
- R7: Reading 0x18 returns the index of the lowest-numbered bit that is both latched and enabled. It returns 0xFFFFFFFF when no bit is both latched and enabled.
- R8: Bits at or above `NUM_IN` in the status, pending and enable words read as zero and cannot be set.
- R9: Reset clears status, enable and master. It also samples the lines, so an edge line that is already high during reset does not latch when reset ends.
- R10: `bus_rdata` is registered. It shows the value from the cycle of the read strobe after the next clock edge and holds that value until the next read. `irq_req` is registered and matches the state after the same edge. Writes to 0x00, 0x04 and 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt lines, synchronous to clk |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | Interrupt request to the processor, registered |

## Verification
The bench tries the trigger logic with three patterns:
- A line held high across reset and across an acknowledge. This separates edge lines from level lines, because only a level line latches again.
- A low-high-low pulse, and a rise placed in the same cycle as its acknowledge. These show whether the clear or the new capture wins.
- Several level lines latched together. These are used while enable bits are set and cleared one by one, and the vector read shows whether the lowest pending and enabled index is chosen.

A long phase of random line activity mixed with random register traffic then compares `irq_req` and `bus_rdata` with a behavioural model on every clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 5;

  typedef enum logic [2:0] {
    W_STATUS = 3'd0,
    W_PEND   = 3'd1,
    W_ENABLE = 3'd2,
    W_ACK    = 3'd3,
    W_SETEN  = 3'd4,
    W_CLREN  = 3'd5,
    W_VECTOR = 3'd6,
    W_MASTER = 3'd7
  } reg_word_e;

  localparam logic [BUS_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/irqv_capture.sv
module irqv_capture #(
  parameter int              N        = 32,
  parameter logic [N-1:0]    EDGE_SEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] status_q,
  output logic [N-1:0] status_d,
  output logic [N-1:0] edge_rise
);
  logic [N-1:0] prev_q;
  logic [N-1:0] set_v;

  // one capture cell per line, kind chosen at build time
  for (genvar i = 0; i < N; i++) begin : g_line
    if (EDGE_SEL[i]) begin : g_edge
      // new rising edge survives an acknowledge in the same cycle
      assign set_v[i]     = irq_in[i] & ~prev_q[i];
      assign edge_rise[i] = irq_in[i] & ~prev_q[i];
    end else begin : g_level
      // acknowledge wins for one cycle, line re-latches afterwards
      assign set_v[i]     = irq_in[i] & ~ack_mask[i];
      assign edge_rise[i] = 1'b0;
    end
  end

  assign status_d = (status_q & ~ack_mask) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      prev_q   <= irq_in;
    end else begin
      status_q <= status_d;
      prev_q   <= irq_in;
    end
  end
endmodule

// File: rtl/irqv_enable_bank.sv
module irqv_enable_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_replace,
  input  logic         wr_set,
  input  logic         wr_clear,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] en_d
);
  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;

  assign set_bits = wr_set   ? wdata : '0;
  assign clr_bits = wr_clear ? wdata : '0;

  always_comb begin
    if (wr_replace) en_d = wdata;
    else            en_d = (en_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irqv_lowest_first.sv
module irqv_lowest_first #(
  parameter int N     = 32,
  parameter int OUT_W = 32
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [OUT_W-1:0] index
);
  // scanning downward leaves the lowest set bit as the winner
  always_comb begin
    found = 1'b0;
    index = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        index = OUT_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int                NUM_IN    = 32,
  parameter logic [NUM_IN-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req
);
  logic              aligned;
  reg_word_e         word;
  logic              wr_ok;
  logic [NUM_IN-1:0] wdata_n;
  logic [NUM_IN-1:0] ack_mask;
  logic [NUM_IN-1:0] status_q, status_d, edge_rise;
  logic [NUM_IN-1:0] en_q, en_d;
  logic [NUM_IN-1:0] pend_q;
  logic [1:0]        master_q, master_d;
  logic              vec_found;
  logic [BUS_W-1:0]  vec_index;
  logic [BUS_W-1:0]  rd_mux;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = reg_word_e'(bus_addr[4:2]);
  assign wr_ok   = bus_wr & aligned;
  assign wdata_n = bus_wdata[NUM_IN-1:0];

  assign ack_mask = (wr_ok && word == W_ACK) ? wdata_n : '0;

  irqv_capture #(.N(NUM_IN), .EDGE_SEL(EDGE_MASK)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .status_q (status_q),
    .status_d (status_d),
    .edge_rise(edge_rise)
  );

  irqv_enable_bank #(.N(NUM_IN)) u_en (
    .clk       (clk),
    .rst       (rst),
    .wr_replace(wr_ok && word == W_ENABLE),
    .wr_set    (wr_ok && word == W_SETEN),
    .wr_clear  (wr_ok && word == W_CLREN),
    .wdata     (wdata_n),
    .en_q      (en_q),
    .en_d      (en_d)
  );

  assign master_d = (wr_ok && word == W_MASTER) ? bus_wdata[1:0] : master_q;

  always_ff @(posedge clk) begin
    if (rst) master_q <= 2'b00;
    else     master_q <= master_d;
  end

  assign pend_q = status_q & en_q;

  irqv_lowest_first #(.N(NUM_IN), .OUT_W(BUS_W)) u_prio (
    .req  (pend_q),
    .found(vec_found),
    .index(vec_index)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (word)
        W_STATUS: rd_mux = BUS_W'(status_q);
        W_PEND:   rd_mux = BUS_W'(pend_q);
        W_ENABLE: rd_mux = BUS_W'(en_q);
        W_VECTOR: rd_mux = vec_found ? vec_index : NO_VECTOR;
        W_MASTER: rd_mux = BUS_W'(master_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  // both outputs registered; the request follows next-state so it lines up with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_req <= (&master_d) & (|(status_d & en_d));
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [4:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic         irq_req,
  input logic [N-1:0] status_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] edge_rise,
  input logic [1:0]   master_q
);
  a_r2_req_needs_master: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (master_q == 2'b11));

  a_r10_req_has_pending: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (|(status_q & en_q)));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 5'h0C) |=>
      ((status_q & $past(bus_wdata[N-1:0]) & ~$past(edge_rise)) == '0));

  a_r4_set_enable: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 5'h10) |=>
      ((en_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

  a_r4_clear_enable: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 5'h14) |=>
      ((en_q & $past(bus_wdata[N-1:0])) == '0));

  a_r7_idle_vector: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 5'h18 && (status_q & en_q) == '0) |=>
      (bus_rdata == 32'hFFFF_FFFF));
endmodule

bind irq_vector_ctrl irqv_checker #(.N(NUM_IN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_req  (irq_req),
  .status_q (status_q),
  .en_q     (en_q),
  .edge_rise(edge_rise),
  .master_q (master_q)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  localparam int          N    = 20;
  localparam logic [19:0] EDGE = 20'h0F0F0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] irq_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_IN(N), .EDGE_MASK(EDGE)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R9";

  // behavioural reference state
  logic [31:0] m_status = '0, m_en = '0, m_prev = '0, m_rdata = '0;
  logic [1:0]  m_mer = '0;
  logic        m_req = 1'b0;

  function automatic logic [31:0] m_vector();
    for (int i = 0; i < N; i++)
      if (m_status[i] && m_en[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      5'h00:   return m_status;
      5'h04:   return m_status & m_en;
      5'h08:   return m_en;
      5'h18:   return m_vector();
      5'h1C:   return {30'h0, m_mer};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] ns, nen;
    logic [1:0]  nmer;
    logic        acked, wok;
    if (rst) begin
      m_status = '0; m_en = '0; m_mer = '0; m_rdata = '0; m_req = 1'b0;
      m_prev = 32'(irq_in);
      return;
    end
    wok = bus_wr && (bus_addr[1:0] == 2'b00);
    if (bus_rd) m_rdata = m_read(bus_addr);
    ns = m_status;
    for (int i = 0; i < N; i++) begin
      acked = wok && bus_addr == 5'h0C && bus_wdata[i];
      if (acked) ns[i] = 1'b0;
      if (EDGE[i] && irq_in[i] && !m_prev[i]) ns[i] = 1'b1;
      if (!EDGE[i] && irq_in[i] && !acked) ns[i] = 1'b1;
    end
    nen = m_en;
    if (wok && bus_addr == 5'h08) nen = bus_wdata & 32'h000F_FFFF;
    if (wok && bus_addr == 5'h10) nen = nen | (bus_wdata & 32'h000F_FFFF);
    if (wok && bus_addr == 5'h14) nen = nen & ~bus_wdata;
    nmer = (wok && bus_addr == 5'h1C) ? bus_wdata[1:0] : m_mer;
    m_status = ns; m_en = nen; m_mer = nmer;
    m_prev = 32'(irq_in);
    m_req = (nmer == 2'b11) && ((ns & nen) != 0);
  endtask

  task automatic compare();
    checks++;
    if (irq_req !== m_req) begin
      fails++;
      $display("FAIL %s irq_req actual=%0b expected=%0b t=%0t", cur_req, irq_req, m_req, $time);
    end
    checks++;
    if (bus_rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s bus_rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_rdata, $time);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic expect_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_req(input logic exp, input string tag);
    checks++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s irq_req actual=%0b expected=%0b", tag, irq_req, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset with an edge line (4) and a level line (0) already high
    irq_in = 20'h00011;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    expect_read(5'h00, 32'h1, "R9");
    expect_read(5'h08, 32'h0, "R9");
    expect_read(5'h1C, 32'h0, "R9");
    expect_req(1'b0, "R9");

    cur_req = "R2";
    bus_write(5'h1C, 32'h5);
    expect_read(5'h1C, 32'h1, "R2");
    bus_write(5'h1C, 32'h3);
    expect_read(5'h1C, 32'h3, "R2");

    cur_req = "R8";
    bus_write(5'h08, 32'hFFFF_FFFF);
    expect_read(5'h08, 32'h000F_FFFF, "R8");
    cur_req = "R4";
    bus_write(5'h14, 32'h0000_F0F0);
    expect_read(5'h08, 32'h000F_0F0F, "R4");
    bus_write(5'h10, 32'h0000_0010);
    expect_read(5'h08, 32'h000F_0F1F, "R4");
    bus_write(5'h08, 32'h0);
    expect_read(5'h08, 32'h0, "R4");
    bus_write(5'h08, 32'h000F_FFFF);

    cur_req = "R7";
    expect_req(1'b1, "R7");
    expect_read(5'h18, 32'h0, "R7");

    // R6: acknowledge while the level line stays high
    cur_req = "R6";
    bus_write(5'h0C, 32'h1);
    expect_read(5'h00, 32'h0, "R6");
    expect_read(5'h00, 32'h1, "R6");
    irq_in[0] = 1'b0;
    bus_write(5'h0C, 32'h1);
    expect_read(5'h00, 32'h0, "R6");

    // R5: edge line
    cur_req = "R5";
    irq_in[4] = 1'b0; tick();
    irq_in[4] = 1'b1; tick();
    expect_read(5'h00, 32'h10, "R5");
    bus_write(5'h0C, 32'h10);
    expect_read(5'h00, 32'h0, "R5");
    expect_read(5'h00, 32'h0, "R5");
    irq_in[4] = 1'b0; tick();
    irq_in[4] = 1'b1;
    bus_write(5'h0C, 32'h10);
    expect_read(5'h00, 32'h10, "R5");

    cur_req = "R3";
    bus_write(5'h0C, 32'h0);
    expect_read(5'h00, 32'h10, "R3");

    // R7 and R1: several pending lines
    cur_req = "R7";
    irq_in[9] = 1'b1; irq_in[17] = 1'b1; tick();
    expect_read(5'h18, 32'd4, "R7");
    bus_write(5'h0C, 32'h10);
    expect_read(5'h18, 32'd9, "R7");
    cur_req = "R1";
    bus_write(5'h14, 32'h200);
    expect_read(5'h18, 32'd17, "R1");
    expect_read(5'h04, 32'h20000, "R1");
    expect_read(5'h00, 32'h20200, "R1");
    expect_read(5'h0C, 32'h0, "R1");
    expect_read(5'h01, 32'h0, "R1");
    irq_in = '0; tick();
    bus_write(5'h0C, 32'hFFFF_FFFF);
    expect_read(5'h18, 32'hFFFF_FFFF, "R7");
    expect_req(1'b0, "R7");

    cur_req = "R10";
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_write(5'h18, 32'hFFFF_FFFF);
    expect_read(5'h00, 32'h0, "R10");
    tick();
    expect_read(5'h00, 32'h0, "R10");

    // R2: gating by each master bit
    cur_req = "R2";
    bus_write(5'h08, 32'h000F_FFFF);
    irq_in[2] = 1'b1;
    bus_write(5'h1C, 32'h1); tick();
    expect_req(1'b0, "R2");
    bus_write(5'h1C, 32'h2); tick();
    expect_req(1'b0, "R2");
    bus_write(5'h1C, 32'h3);
    expect_req(1'b1, "R2");
    irq_in[2] = 1'b0;
    bus_write(5'h0C, 32'h4);

    // random traffic compared against the model every cycle
    cur_req = "R1";
    for (int k = 0; k < 3000; k++) begin
      int op;
      irq_in = irq_in ^ (20'($urandom) & 20'($urandom) & 20'($urandom));
      op = $urandom % 4;
      bus_addr = 5'(($urandom % 8) * 4);
      bus_wdata = $urandom;
      if (bus_addr == 5'h1C && ($urandom % 4) != 0) bus_wdata = 32'h3;
      bus_wr = (op == 1);
      bus_rd = (op >= 2);
      tick();
      bus_wr = 1'b0; bus_rd = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule